// File: doc/BRIEF.md
# Full-Duplex SPI Transaction Engine

This block is a serial-bus master that carries out one full-duplex exchange of up to four bytes for each start request. A request supplies four transmit bytes, an 8-bit slave-select mask and a byte count. The engine first checks the request. A valid request drives the selected active-low slave select. The engine then exchanges the requested number of bytes, most significant bit first, and releases every select. It finishes with a one-cycle completion pulse, a status bit and the bytes it received.

Only one clock mode exists. The serial clock idles low. Output data changes while the clock is low. Input data is sampled while the clock is high, at the end of the high phase. Each received byte takes the place of the transmitted byte it was exchanged with. The length of each clock phase comes from a divider value that is captured when the request is accepted.

Top module: `spi_xact_engine`

## Requirements
- R1: A `start` pulse that arrives while `busy` is high is ignored: it produces no extra `done` and does not change the running exchange.
- R2: A request whose `sel_mask` has two or more bits set is rejected. `done` pulses with `ok`=0, no select is ever driven low, no serial clock edge occurs and `rx_data` reads zero.
- R3: A request whose `xfer_len` is greater than 4 is rejected in the same way as R2: `ok`=0, no select, no clock edge and `rx_data` zero.
- R4: A request with `xfer_len`=0 and a valid mask succeeds with `ok`=1. The selected line goes low and is then released, no clock edge occurs and `rx_data` reads zero.
- R5: Transmit byte k is `tx_data[8k+7:8k]`. Bytes 0 to `xfer_len`-1 are sent in that order, each most significant bit first. `mosi` only changes while `sclk` is low.
- R6: `miso` is sampled once in each high phase of `sclk`, and the bits are assembled MSB first. The received byte k appears at `rx_data[8k+7:8k]`. Lanes at index `xfer_len` and above read zero.
- R7: Each high and each low phase of `sclk` between clock pulses lasts `half_div`+1 system clock cycles. The value used is the one present on the accepted `start`; later changes to `half_div` have no effect on the running exchange.
- R8: `cs_n` is active low. The bit selected by the mask is low for the whole exchange. All bits are high whenever `busy` is low and when `done` pulses. `sclk` is low while idle.
- R9: `busy` rises on the cycle after an accepted `start`. `done` is a single-cycle pulse carrying `ok`. `busy` falls on the cycle after `done`. `rx_data` holds its value until the next `done`.
- R10: An accepted request produces exactly 8×`xfer_len` rising edges of `sclk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| tx_data | input | 32 | Transmit bytes, byte k at bits 8k+7:8k |
| sel_mask | input | 8 | Slave-select mask, at most one bit set |
| xfer_len | input | 8 | Byte count, 0 to 4 accepted |
| half_div | input | 8 | Serial clock half-period minus one, in system cycles |
| miso | input | 1 | Serial data from the slave |
| busy | output | 1 | High from the cycle after start until after done |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Status of the request, valid with done |
| rx_data | output | 32 | Received bytes, byte k at bits 8k+7:8k |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 8 | Active-low slave selects |

## Verification
The embedded checks assume that `start` is a single-cycle strobe and that the external slave changes `miso` only after a falling edge of `sclk`. Under that assumption, a bit is never sampled while it is moving. The bench slave model meets this: it advances its output bit only when it sees `sclk` fall, and it captures `mosi` only when it sees `sclk` rise. The stimulus never relies on `half_div` staying constant. It deliberately changes the divider during an exchange, and it fires a second `start` during a busy period, so that those inputs are shown to have no effect.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;

    localparam int XACT_BYTE_W    = 8;
    localparam int XACT_MAX_BYTES = 4;
    localparam int XACT_SEL_W     = 8;
    localparam int XACT_LEN_W     = 8;
    localparam int XACT_DIV_W     = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LOW   = 3'd2,
        ST_HIGH  = 3'd3,
        ST_STOP  = 3'd4,
        ST_DONE  = 3'd5
    } xact_state_e;

    function automatic logic in_bit_phase(xact_state_e st);
        return (st == ST_LOW) || (st == ST_HIGH);
    endfunction

endpackage

// File: rtl/spi_req_check.sv
module spi_req_check #(
    parameter int SEL_W     = 8,
    parameter int LEN_W     = 8,
    parameter int MAX_BYTES = 4
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [LEN_W-1:0] len,
    output logic             valid,
    output logic             empty
);
    localparam int CNT_W = $clog2(SEL_W + 1);

    logic [CNT_W-1:0] sel_count;
    logic             mask_fine;
    logic             len_fine;

    always_comb begin
        sel_count = '0;
        for (int i = 0; i < SEL_W; i++) begin
            sel_count = sel_count + CNT_W'(sel[i]);
        end
    end

    assign mask_fine = (sel_count <= CNT_W'(1));
    assign len_fine  = (len <= LEN_W'(MAX_BYTES));
    assign valid     = mask_fine && len_fine;
    assign empty     = (len == '0);

endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             run,
    input  logic             restart,
    output logic             expire
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            div_q <= div_in;
            cnt_q <= div_in;
        end else if (restart) begin
            cnt_q <= div_q;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run && (cnt_q == '0);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= div_q); // R7

    AST_TIMER_HELD: assert property (@(posedge clk) disable iff (rst)
        (run && !load) |=> $stable(div_q)); // R7

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4,
    parameter int LEN_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [NUM_BYTES*BYTE_W-1:0] tx_vec,
    input  logic [LEN_W-1:0]            len_in,
    input  logic                        shift,
    input  logic                        miso,
    output logic                        out_bit,
    output logic                        final_bit,
    output logic [NUM_BYTES*BYTE_W-1:0] rx_vec
);
    localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
    localparam int BIT_W = $clog2(BYTE_W);

    logic [NUM_BYTES-1:0][BYTE_W-1:0] lanes_q;
    logic [IDX_W-1:0]                 idx_q;
    logic [BIT_W-1:0]                 bit_q;
    logic [LEN_W-1:0]                 len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lanes_q <= '0;
            idx_q   <= '0;
            bit_q   <= '0;
            len_q   <= '0;
        end else if (load) begin
            lanes_q <= tx_vec;
            idx_q   <= '0;
            bit_q   <= '0;
            len_q   <= len_in;
        end else if (shift) begin
            lanes_q[idx_q] <= {lanes_q[idx_q][BYTE_W-2:0], miso};
            if (bit_q == BIT_W'(BYTE_W - 1)) begin
                bit_q <= '0;
                idx_q <= idx_q + 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    assign out_bit   = lanes_q[idx_q][BYTE_W-1];
    assign final_bit = (bit_q == BIT_W'(BYTE_W - 1)) &&
                       ((LEN_W'(idx_q) + 1'b1) == len_q);

    generate
        for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
            assign rx_vec[k*BYTE_W +: BYTE_W] =
                (LEN_W'(k) < len_q) ? lanes_q[k] : '0;
        end
    endgenerate

    AST_NO_EMPTY_SHIFT: assert property (@(posedge clk) disable iff (rst)
        shift |-> (len_q != '0)); // R4

    AST_SHIFT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        shift |-> (LEN_W'(idx_q) < len_q)); // R10

endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine
    import spi_xact_pkg::*;
#(
    parameter int BYTE_W    = XACT_BYTE_W,
    parameter int NUM_BYTES = XACT_MAX_BYTES,
    parameter int SEL_W     = XACT_SEL_W,
    parameter int LEN_W     = XACT_LEN_W,
    parameter int DIV_W     = XACT_DIV_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [NUM_BYTES*BYTE_W-1:0] tx_data,
    input  logic [SEL_W-1:0]            sel_mask,
    input  logic [LEN_W-1:0]            xfer_len,
    input  logic [DIV_W-1:0]            half_div,
    input  logic                        miso,
    output logic                        busy,
    output logic                        done,
    output logic                        ok,
    output logic [NUM_BYTES*BYTE_W-1:0] rx_data,
    output logic                        sclk,
    output logic                        mosi,
    output logic [SEL_W-1:0]            cs_n
);
    localparam int VEC_W = NUM_BYTES * BYTE_W;

    xact_state_e      state_q;
    logic [SEL_W-1:0] sel_q;
    logic [LEN_W-1:0] len_q;
    logic             ok_q;
    logic             sclk_q;
    logic [SEL_W-1:0] cs_n_q;
    logic [VEC_W-1:0] rx_q;

    logic             accept;
    logic             req_valid;
    logic             req_empty;
    logic             phase_run;
    logic             phase_end;
    logic             shift_now;
    logic             out_bit;
    logic             final_bit;
    logic [VEC_W-1:0] rx_vec;

    assign accept    = start && (state_q == ST_IDLE);
    assign phase_run = in_bit_phase(state_q);
    assign shift_now = (state_q == ST_HIGH) && phase_end;

    spi_req_check #(
        .SEL_W    (SEL_W),
        .LEN_W    (LEN_W),
        .MAX_BYTES(NUM_BYTES)
    ) u_check (
        .sel  (sel_q),
        .len  (len_q),
        .valid(req_valid),
        .empty(req_empty)
    );

    spi_half_timer #(
        .DIV_W(DIV_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .div_in (half_div),
        .run    (phase_run),
        .restart(phase_end),
        .expire (phase_end)
    );

    spi_byte_shifter #(
        .BYTE_W   (BYTE_W),
        .NUM_BYTES(NUM_BYTES),
        .LEN_W    (LEN_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .tx_vec   (tx_data),
        .len_in   (xfer_len),
        .shift    (shift_now),
        .miso     (miso),
        .out_bit  (out_bit),
        .final_bit(final_bit),
        .rx_vec   (rx_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            len_q   <= '0;
            ok_q    <= 1'b0;
            sclk_q  <= 1'b0;
            cs_n_q  <= '1;
            rx_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        sel_q   <= sel_mask;
                        len_q   <= xfer_len;
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (!req_valid) begin
                        ok_q    <= 1'b0;
                        state_q <= ST_STOP;
                    end else begin
                        ok_q    <= 1'b1;
                        cs_n_q  <= ~sel_q;
                        state_q <= req_empty ? ST_STOP : ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (phase_end) begin
                        sclk_q  <= 1'b1;
                        state_q <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (phase_end) begin
                        sclk_q  <= 1'b0;
                        state_q <= final_bit ? ST_STOP : ST_LOW;
                    end
                end
                ST_STOP: begin
                    cs_n_q  <= '1;
                    rx_q    <= ok_q ? rx_vec : '0;
                    state_q <= ST_DONE;
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_DONE);
    assign ok      = ok_q;
    assign rx_data = rx_q;
    assign sclk    = sclk_q;
    assign mosi    = phase_run ? out_bit : 1'b0;
    assign cs_n    = cs_n_q;

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1); // R2

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETUP && !req_valid) |=> (cs_n == '1 && !sclk)); // R3

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sclk && cs_n == '1)); // R8

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n == '1 && !sclk)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R9

    AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R5

    AST_CLOCK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        sclk |-> busy); // R10

endmodule

// File: tb/test_spi_xact_engine.sv
module test_spi_xact_engine;

    typedef struct packed {
        logic        ok;
        logic [31:0] rx;
        logic [31:0] sent;
        logic [7:0]  rises;
        logic [7:0]  sel;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] tx_data = '0;
    logic [7:0]  sel_mask = '0;
    logic [7:0]  xfer_len = '0;
    logic [7:0]  half_div = '0;
    logic        miso;
    logic        busy, done, ok, sclk, mosi;
    logic [31:0] rx_data;
    logic [7:0]  cs_n;

    int checks = 0;
    int fails = 0;
    int pushed = 0;
    int dones = 0;
    int cycles = 0;

    exp_t exp_q[$];

    logic [31:0] slv_resp = '0;
    int          cur_div = 0;

    int          rises = 0, falls = 0, hi_run = 0, lo_run = 0, width_bad = 0;
    logic        had_high = 1'b0;
    logic        sclk_prev = 1'b0;
    logic [31:0] slv_in = '0;
    logic [7:0]  cs_seen = '0;

    always #10 clk = ~clk;

    assign miso = (falls < 32) ? slv_resp[31 - falls] : 1'b0;

    spi_xact_engine i_spi_xact_engine (
        .clk(clk), .rst(rst), .start(start), .tx_data(tx_data),
        .sel_mask(sel_mask), .xfer_len(xfer_len), .half_div(half_div),
        .miso(miso), .busy(busy), .done(done), .ok(ok), .rx_data(rx_data),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            finish_run();
        end
    end

    // monitor: slave model, phase measurement and scoreboard compare
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) cs_seen = cs_seen | ~cs_n;
            if (sclk && !sclk_prev) begin
                rises++;
                slv_in = {slv_in[30:0], mosi};
                if (had_high && lo_run != cur_div + 1) width_bad++;
                hi_run = 1;
            end else if (sclk) begin
                hi_run++;
            end else if (!sclk && sclk_prev) begin
                falls++;
                if (hi_run != cur_div + 1) width_bad++;
                had_high = 1'b1;
                lo_run = 1;
            end else if (had_high) begin
                lo_run++;
            end
            sclk_prev = sclk;
            if (done) begin
                dones++;
                if (exp_q.size() == 0) begin
                    check("R1 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R9 ok status", {31'd0, ok}, {31'd0, e.ok});
                    check("R6 rx bytes", rx_data, e.rx);
                    check("R10 clock rises", rises, {24'd0, e.rises});
                    check("R5 bits sent", slv_in, e.sent);
                    check("R8 select seen", {24'd0, cs_seen}, {24'd0, e.sel});
                    check("R8 released at done", {24'd0, cs_n}, 32'h0000_00ff);
                    if (e.rises != 0) check("R7 phase widths", width_bad, 0);
                end
                rises = 0; falls = 0; hi_run = 0; lo_run = 0; width_bad = 0;
                had_high = 1'b0; slv_in = '0; cs_seen = '0;
            end
        end
    end

    task automatic run_xact(input logic [31:0] tx, input logic [7:0] sel,
                            input logic [7:0] len, input logic [7:0] div,
                            input logic [31:0] resp, input bit poke);
        exp_t e;
        logic        valid;
        int          n;
        int          ones;
        ones = $countones(sel);
        valid = (ones <= 1) && (len <= 4);
        n = valid ? int'(len) : 0;
        e.ok = valid;
        e.rx = '0;
        e.sent = '0;
        for (int k = 0; k < n; k++) begin
            e.rx[k*8 +: 8] = resp[31 - 8*k -: 8];
            e.sent = (e.sent << 8) | {24'd0, tx[k*8 +: 8]};
        end
        e.rises = 8'(8 * n);
        e.sel = valid ? sel : 8'h00;
        exp_q.push_back(e);
        pushed++;
        @(negedge clk);
        slv_resp = resp;
        cur_div = int'(div);
        tx_data = tx; sel_mask = sel; xfer_len = len; half_div = div;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 busy after start", {31'd0, busy}, 32'd1);
        half_div = div + 8'd5;  // R7: change after acceptance must not matter
        if (poke) begin
            repeat (6) @(negedge clk);
            tx_data = 32'hdead_beef; sel_mask = 8'h02; xfer_len = 8'd1;
            start = 1'b1;  // R1: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        check("R9 rx held after done", rx_data, e.rx);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset busy", {31'd0, busy}, 32'd0);
        check("R9 reset done", {31'd0, done}, 32'd0);
        check("R8 reset selects", {24'd0, cs_n}, 32'h0000_00ff);
        check("R8 reset clock", {31'd0, sclk}, 32'd0);
        check("R6 reset rx", rx_data, 32'd0);

        run_xact(32'h44_33_22_11, 8'h01, 8'd4, 8'd0, 32'ha5_5a_c3_3c, 1'b0); // R5 R6
        run_xact(32'h00_00_00_81, 8'h80, 8'd1, 8'd3, 32'h7e_00_00_00, 1'b0); // R7
        run_xact(32'hff_0f_f0_96, 8'h10, 8'd3, 8'd1, 32'h12_34_56_78, 1'b0); // R6 upper lane zero
        run_xact(32'h01_02_03_04, 8'h04, 8'd0, 8'd2, 32'hffff_ffff, 1'b0);   // R4
        run_xact(32'h01_02_03_04, 8'h03, 8'd2, 8'd0, 32'hffff_ffff, 1'b0);   // R2
        run_xact(32'h01_02_03_04, 8'h20, 8'd5, 8'd0, 32'hffff_ffff, 1'b0);   // R3
        run_xact(32'h01_02_03_04, 8'h00, 8'd255, 8'd0, 32'hffff_ffff, 1'b0); // R3
        run_xact(32'h00_00_c0_de, 8'h40, 8'd2, 8'd2, 32'hbe_ef_00_00, 1'b1); // R1
        run_xact(32'h00_00_5a_a5, 8'h00, 8'd2, 8'd0, 32'h0f_f0_00_00, 1'b0); // R10 no select

        repeat (20) @(negedge clk);
        check("R1 done count", dones, pushed);
        check("R1 queue drained", exp_q.size(), 0);
        finish_run();
    end

endmodule